// File: doc/BRIEF.md
# Packet-Interface Auto-Sequencer

This block is the control engine of the device side of a packet-command storage interface. Firmware on the local microcontroller programs one 8-bit control register and a transfer word count. The sequencer then runs the host handshakes on its own: it takes in the command packet, raises data requests for a programmed number of PIO or DMA words, and closes a command by writing the task-file status byte and pulsing the host interrupt. Each sequence clears its own enable bit when it ends, so firmware only starts the next step.

A repeat bit lets firmware queue one more packet reception. It is set together with a data-request command. When that command's data and completion phases have finished, the machine re-enables packet reception by itself. A suspend bit freezes the machine for debug. A status write that is due while the machine is frozen is held back until the bit is cleared.

States: `S_IDLE`, `S_PKT` (packet words), `S_PKT_DONE`, `S_XFER` (data words), `S_XFER_END`, `S_CMPL_WR` (status write), `S_CMPL_IRQ`, `S_SEQ_RST`. Transitions: `S_IDLE→S_PKT` when packet enable is set; `S_IDLE→S_XFER` when data enable is set and the count is non-zero; `S_IDLE→S_XFER_END` when data enable is set and the count is zero; `S_PKT→S_PKT_DONE` on the last packet word; `S_PKT_DONE→S_IDLE`; `S_XFER→S_XFER_END` on the last word, or on a count found at zero; `S_XFER_END→S_CMPL_WR` when completion is enabled, otherwise `S_XFER_END→S_SEQ_RST`; `S_CMPL_WR→S_CMPL_IRQ`; `S_CMPL_IRQ→S_SEQ_RST`; `S_SEQ_RST→S_IDLE`. No transition is taken while suspend is set.

Top module: `hseq_top`

## Requirements
- R1: The control register reads back bit 7 packet enable, bit 6 data enable, bit 5 completion enable, bit 4 error, bit 3 suspend and bit 2 repeat. Bits 1:0 always read 0. A synchronous reset clears every bit.
- R2: With packet enable set, `drq` stays high until 6 words have been accepted (`drq && host_ack` at a clock edge). The machine then clears packet enable and pulses `pkt_irq` for one cycle.
- R3: With data enable set and a count N > 0 loaded, `drq` stays high until exactly N words have been accepted. It then falls, and data enable clears.
- R4: With completion enabled, after the data phase the machine writes one status byte (`stat_we` for one cycle) and pulses `host_irq` in the following cycle. Completion enable then clears.
- R5: The status byte has bit 7 (busy) = 0, bit 6 (ready) = 1, bit 3 (data request) = 0 and bit 0 (check) = the error bit, giving 0x40 or 0x41. The error bit is not cleared by the machine.
- R6: Completion enable with data enable clear has no effect: there is no status write, and the register keeps its value.
- R7: Data enable with a count of 0 raises no `drq` and goes straight to completion, when completion is enabled.
- R8: While suspend is set, the state holds and accepted words are ignored. A status write due in that state is performed only after suspend is cleared.
- R9: At the end of a data or completion sequence, the repeat bit is copied into packet enable. The packet sequence clears the repeat bit, so exactly one extra packet reception occurs.
- R10: When packet enable and data enable are both set, the packet sequence runs first, then the data sequence.
- R11: When a firmware write and a clear by the machine hit the same bit in the same cycle, the clear wins. The other bits take the written value.
- R12: Asserting `rst` during a sequence returns the machine to idle with `drq` low and the register at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| len_we | input | 1 | Word count load strobe |
| len_val | input | CNT_W | Word count to load |
| host_ack | input | 1 | Host accepts one word while `drq` is high |
| drq | output | 1 | Data request toward the host |
| stat_we | output | 1 | Status register write strobe |
| stat_wdata | output | 8 | Status byte being written |
| host_irq | output | 1 | One-cycle interrupt toward the host |
| pkt_irq | output | 1 | One-cycle packet-received interrupt to the microcontroller |

## Verification
Two events can land in the same cycle: a firmware write to the control register, and the machine clearing an enable bit at the end of a sequence. The bench provokes this by issuing a write that sets data enable and suspend in the very cycle that `S_XFER_END` clears data enable. It then reads back that data enable is clear while suspend took effect. The same collision freezes the machine inside the status-write state, so the bench also checks that no status byte appears until suspend is released, and that the byte then carries the check bit.

// File: rtl/hseq_pkg.sv
package hseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PKT,
        S_PKT_DONE,
        S_XFER,
        S_XFER_END,
        S_CMPL_WR,
        S_CMPL_IRQ,
        S_SEQ_RST
    } seq_state_t;

    // control register bit positions (firmware-visible)
    localparam int B_PKT = 7;
    localparam int B_DRQ = 6;
    localparam int B_CMP = 5;
    localparam int B_ERR = 4;
    localparam int B_SUS = 3;
    localparam int B_RPT = 2;

    // status byte bit positions (host-visible)
    localparam int ST_BSY = 7;
    localparam int ST_RDY = 6;
    localparam int ST_DRQ = 3;
    localparam int ST_CHK = 0;

    typedef struct packed {
        logic pkt;
        logic drq;
        logic cmp;
        logic err;
        logic sus;
        logic rpt;
    } ctrl_t;

endpackage

// File: rtl/hseq_ctrl_reg.sv
module hseq_ctrl_reg
    import hseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_we,
    input  logic [7:0] cpu_wdata,
    input  logic       clr_pkt,
    input  logic       clr_rpt,
    input  logic       clr_drq,
    input  logic       clr_cmp,
    input  logic       rearm,
    output ctrl_t      ctrl,
    output logic [7:0] rdata
);

    ctrl_t nxt;

    always_comb begin
        nxt = ctrl;
        if (cpu_we) begin
            nxt.pkt = cpu_wdata[B_PKT];
            nxt.drq = cpu_wdata[B_DRQ];
            nxt.cmp = cpu_wdata[B_CMP];
            nxt.err = cpu_wdata[B_ERR];
            nxt.sus = cpu_wdata[B_SUS];
            nxt.rpt = cpu_wdata[B_RPT];
        end
        // sequencer updates override the firmware write on the bits they touch
        if (clr_pkt) nxt.pkt = 1'b0;
        if (clr_rpt) nxt.rpt = 1'b0;
        if (clr_drq) nxt.drq = 1'b0;
        if (clr_cmp) nxt.cmp = 1'b0;
        if (rearm)   nxt.pkt = ctrl.rpt;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl <= '0;
        else     ctrl <= nxt;
    end

    always_comb begin
        rdata         = '0;
        rdata[B_PKT]  = ctrl.pkt;
        rdata[B_DRQ]  = ctrl.drq;
        rdata[B_CMP]  = ctrl.cmp;
        rdata[B_ERR]  = ctrl.err;
        rdata[B_SUS]  = ctrl.sus;
        rdata[B_RPT]  = ctrl.rpt;
    end

    assert_hw_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
        $past(clr_drq) |-> !ctrl.drq);
    assert_pkt_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
        $past(clr_pkt) |-> !ctrl.pkt);

endmodule

// File: rtl/hseq_word_cnt.sv
module hseq_word_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             cnt_zero,
    output logic             cnt_last
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - ONE;
    end

    assign cnt_zero = (cnt == '0);
    assign cnt_last = (cnt == ONE);

    assert_cnt_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        dec |-> !cnt_zero);

endmodule

// File: rtl/hseq_fsm.sv
module hseq_fsm
    import hseq_pkg::*;
#(
    parameter int PKT_WORDS = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  ctrl_t      ctrl,
    input  logic       host_ack,
    input  logic       cnt_zero,
    input  logic       cnt_last,
    output logic       drq,
    output logic       cnt_dec,
    output logic       pkt_irq,
    output logic       host_irq,
    output logic       stat_we,
    output logic [7:0] stat_wdata,
    output logic       clr_pkt,
    output logic       clr_rpt,
    output logic       clr_drq,
    output logic       clr_cmp,
    output logic       rearm
);

    localparam int PW = $clog2(PKT_WORDS + 1);
    localparam logic [PW-1:0] PKT_LAST = PW'(PKT_WORDS - 1);

    seq_state_t      state, nxt;
    logic [PW-1:0]   pcnt;
    logic            go;
    logic            pkt_take;

    assign go       = !ctrl.sus;
    assign pkt_take = (state == S_PKT) && host_ack;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (ctrl.pkt)      nxt = S_PKT;
                else if (ctrl.drq) nxt = cnt_zero ? S_XFER_END : S_XFER;
            end
            S_PKT:      if (pkt_take && pcnt == PKT_LAST) nxt = S_PKT_DONE;
            S_PKT_DONE: nxt = S_IDLE;
            S_XFER: begin
                if (cnt_zero)                  nxt = S_XFER_END;
                else if (host_ack && cnt_last) nxt = S_XFER_END;
            end
            S_XFER_END: nxt = ctrl.cmp ? S_CMPL_WR : S_SEQ_RST;
            S_CMPL_WR:  nxt = S_CMPL_IRQ;
            S_CMPL_IRQ: nxt = S_SEQ_RST;
            S_SEQ_RST:  nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // state register and packet word counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            pcnt  <= '0;
        end else if (go) begin
            state <= nxt;
            if (pkt_take) pcnt <= (pcnt == PKT_LAST) ? '0 : pcnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        drq        = 1'b0;
        cnt_dec    = 1'b0;
        pkt_irq    = 1'b0;
        host_irq   = 1'b0;
        stat_we    = 1'b0;
        stat_wdata = '0;
        clr_pkt    = 1'b0;
        clr_rpt    = 1'b0;
        clr_drq    = 1'b0;
        clr_cmp    = 1'b0;
        rearm      = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_PKT:  drq = 1'b1;
            S_PKT_DONE: begin
                pkt_irq = go;
                clr_pkt = go;
                clr_rpt = go;
            end
            S_XFER: begin
                drq     = 1'b1;
                cnt_dec = go && host_ack && !cnt_zero;
            end
            S_XFER_END: clr_drq = go;
            S_CMPL_WR: begin
                stat_we = go;
                if (go) begin
                    stat_wdata[ST_BSY] = 1'b0;
                    stat_wdata[ST_RDY] = 1'b1;
                    stat_wdata[ST_DRQ] = 1'b0;
                    stat_wdata[ST_CHK] = ctrl.err;
                end
            end
            S_CMPL_IRQ: begin
                host_irq = go;
                clr_cmp  = go;
            end
            S_SEQ_RST: rearm = go;
            default: ;
        endcase
    end

    assert_pkt_irq_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        pkt_irq |=> !pkt_irq);
    assert_irq_after_write_R4: assert property (@(posedge clk) disable iff (rst)
        host_irq |-> ($past(stat_we) || $past(ctrl.sus)));
    assert_susp_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        ctrl.sus |=> $stable(state));
    assert_susp_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        ctrl.sus |-> (!stat_we && !host_irq && !pkt_irq));

endmodule

// File: rtl/hseq_top.sv
module hseq_top
    import hseq_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PKT_WORDS = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             len_we,
    input  logic [CNT_W-1:0] len_val,
    input  logic             host_ack,
    output logic             drq,
    output logic             stat_we,
    output logic [7:0]       stat_wdata,
    output logic             host_irq,
    output logic             pkt_irq
);

    ctrl_t ctrl;
    logic  clr_pkt, clr_rpt, clr_drq, clr_cmp, rearm;
    logic  cnt_dec, cnt_zero, cnt_last;

    hseq_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cpu_we    (cfg_we),
        .cpu_wdata (cfg_wdata),
        .clr_pkt   (clr_pkt),
        .clr_rpt   (clr_rpt),
        .clr_drq   (clr_drq),
        .clr_cmp   (clr_cmp),
        .rearm     (rearm),
        .ctrl      (ctrl),
        .rdata     (cfg_rdata)
    );

    hseq_word_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (len_we),
        .load_val (len_val),
        .dec      (cnt_dec),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last)
    );

    hseq_fsm #(.PKT_WORDS(PKT_WORDS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .host_ack   (host_ack),
        .cnt_zero   (cnt_zero),
        .cnt_last   (cnt_last),
        .drq        (drq),
        .cnt_dec    (cnt_dec),
        .pkt_irq    (pkt_irq),
        .host_irq   (host_irq),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata),
        .clr_pkt    (clr_pkt),
        .clr_rpt    (clr_rpt),
        .clr_drq    (clr_drq),
        .clr_cmp    (clr_cmp),
        .rearm      (rearm)
    );

    assert_no_drq_in_reset_R12: assert property (@(posedge clk)
        $past(rst) |-> !drq);

endmodule

// File: tb/sim_hseq_top.sv
`timescale 1ns/1ps
module sim_hseq_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        len_we = 1'b0;
    logic [15:0] len_val = '0;
    logic        ack_en = 1'b0;
    logic        host_ack;
    logic        drq, stat_we, host_irq, pkt_irq;
    logic [7:0]  stat_wdata;

    int total = 0;
    int fails = 0;
    int acks = 0, nstat = 0, nirq = 0, npkt = 0, acks_at_pkt = 0;
    int cyc = 0, stat_cyc = 0, irq_cyc = 0;
    logic [7:0] last_stat = '0;

    always #5 clk = ~clk;

    assign host_ack = ack_en & drq;

    hseq_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .len_we(len_we), .len_val(len_val),
        .host_ack(host_ack), .drq(drq), .stat_we(stat_we),
        .stat_wdata(stat_wdata), .host_irq(host_irq), .pkt_irq(pkt_irq)
    );

    // host-bus observer
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (drq && host_ack) acks <= acks + 1;
            if (stat_we) begin
                nstat     <= nstat + 1;
                last_stat <= stat_wdata;
                stat_cyc  <= cyc;
            end
            if (host_irq) begin
                nirq    <= nirq + 1;
                irq_cyc <= cyc;
            end
            if (pkt_irq) begin
                npkt        <= npkt + 1;
                acks_at_pkt <= acks;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic load_len(input logic [15:0] v);
        len_we = 1'b1; len_val = v;
        tick(1);
        len_we = 1'b0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {len[15:8], unused[7:2], cmp[1], err[0]}
    localparam logic [15:0] VEC [0:3] = '{16'h0102, 16'h0303, 16'h0500, 16'h0201};

    initial begin
        #1_000_000;
        total++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        int a0, s0, i0, p0;
        tick(3);
        rst = 1'b0;
        tick(1);
        // reset state R1 R12
        chk("R1 reset rdata", cfg_rdata, 8'h00);
        chk("R12 reset drq", drq, 0);

        // R1 readback, unused bits read 0
        cfg_write(8'h1B);
        chk("R1 readback", cfg_rdata, 8'h18);
        cfg_write(8'h00);

        // vector table: data phase with and without completion R3 R4 R5
        for (int v = 0; v < 4; v++) begin
            int len;
            logic cmp, err;
            len = int'(VEC[v][15:8]);
            cmp = VEC[v][1];
            err = VEC[v][0];
            a0 = acks; s0 = nstat; i0 = nirq;
            load_len(16'(len));
            cfg_write(8'h40 | {2'b00, cmp, err, 4'h0});
            ack_en = 1'b1;
            tick(len + 10);
            ack_en = 1'b0;
            chk("R3 words accepted", acks - a0, len);
            chk("R3 drq low after", drq, 0);
            chk("R4 status writes", nstat - s0, cmp ? 1 : 0);
            chk("R4 host irq count", nirq - i0, cmp ? 1 : 0);
            if (cmp) begin
                chk("R5 status byte", last_stat, 8'h40 | {7'h0, err});
                chk("R4 irq one cycle after write", irq_cyc - stat_cyc, 1);
            end
            chk("R5 rdata after", cfg_rdata, err ? 8'h10 : 8'h00);
            cfg_write(8'h00);
        end

        // R2 packet reception
        a0 = acks; p0 = npkt;
        cfg_write(8'h80);
        ack_en = 1'b1;
        tick(15);
        ack_en = 1'b0;
        chk("R2 packet words", acks - a0, 6);
        chk("R2 pkt irq", npkt - p0, 1);
        chk("R2 pkt enable cleared", cfg_rdata, 8'h00);

        // R6 completion without data enable
        s0 = nstat;
        cfg_write(8'h20);
        tick(8);
        chk("R6 no status write", nstat - s0, 0);
        chk("R6 register kept", cfg_rdata, 8'h20);
        cfg_write(8'h00);

        // R7 zero length
        a0 = acks; s0 = nstat;
        load_len(16'd0);
        cfg_write(8'h60);
        ack_en = 1'b1;
        tick(8);
        ack_en = 1'b0;
        chk("R7 no words", acks - a0, 0);
        chk("R7 status written", nstat - s0, 1);
        chk("R7 status byte", last_stat, 8'h40);

        // R9 repeat: one extra packet after data phase
        a0 = acks; p0 = npkt;
        load_len(16'd2);
        cfg_write(8'h44);
        ack_en = 1'b1;
        tick(30);
        chk("R9 words total", acks - a0, 8);
        chk("R9 one packet", npkt - p0, 1);
        chk("R9 repeat cleared", cfg_rdata, 8'h00);
        tick(10);
        ack_en = 1'b0;
        chk("R9 exactly one extra", acks - a0, 8);

        // R10 packet before data
        a0 = acks;
        load_len(16'd2);
        cfg_write(8'hC0);
        ack_en = 1'b1;
        tick(30);
        ack_en = 1'b0;
        chk("R10 packet first", acks_at_pkt - a0, 6);
        chk("R10 all words", acks - a0, 8);

        // R8 suspend during data phase: accepted words ignored
        load_len(16'd3);
        cfg_write(8'h40);
        tick(3);
        cfg_write(8'h48);
        ack_en = 1'b1;
        tick(5);
        ack_en = 1'b0;
        chk("R8 drq held", drq, 1);
        chk("R8 rdata held", cfg_rdata, 8'h48);
        cfg_write(8'h40);
        a0 = acks;
        ack_en = 1'b1;
        tick(10);
        ack_en = 1'b0;
        chk("R8 full count after release", acks - a0, 3);

        // R11 + R8: write collides with data-enable clear, freezes in status write
        s0 = nstat; i0 = nirq;
        load_len(16'd1);
        cfg_write(8'h70);
        tick(3);
        ack_en = 1'b1;
        tick(1);
        ack_en = 1'b0;
        cfg_write(8'h78);
        tick(5);
        chk("R11 clear wins", cfg_rdata, 8'h38);
        chk("R8 write held back", nstat - s0, 0);
        cfg_write(8'h30);
        tick(4);
        chk("R8 write after release", nstat - s0, 1);
        chk("R5 check bit set", last_stat, 8'h41);
        chk("R4 irq after release", nirq - i0, 1);
        chk("R5 error kept", cfg_rdata, 8'h10);

        // R12 reset mid-sequence
        cfg_write(8'h80);
        tick(3);
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        tick(3);
        chk("R12 rdata cleared", cfg_rdata, 8'h00);
        chk("R12 drq low", drq, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

endmodule